// File: doc/BRIEF.md
# Three-Channel Digital Fine Clamp

This block removes black-level drift from component video samples. It runs one independent feedback loop per channel (A, B, C). Each loop watches the samples that arrive while the back-porch window strobe is high and forms their average. It then compares that average with a programmable black-level target. The difference becomes a signed offset, which is added to every sample of the channel. The corrected value is clipped to the legal code range.

An offset register changes only at a line-start strobe. Each loop takes its offset from one of three sources: that line's back-porch measurement (automatic), a static value from a register input (manual), or its own previous value (frozen). Channel A has its own mode and target. Channels B and C share a mode and a target but take separate manual offsets. The corrected samples appear one clock after the input samples, with a matching valid flag.

Top module: `vid_clamp_top`

## Requirements
- R1: After reset every channel offset is zero, so each valid sample passes through unchanged until the first line-start strobe that loads a new offset. `out_vld` is low while reset is applied.
- R2: Each corrected output equals the input sample plus that channel's signed offset, clipped to the range 0 to 2^DW−1. It appears exactly one clock after the input. `out_vld` is `in_vld` delayed by one clock, and exactly one output is produced per valid input.
- R3: The back-porch level of a channel is the sum of the first 16 samples (2^AVG_LOG2) taken in cycles where `bp_win` and `in_vld` are both high, shifted right by 4. Samples beyond the 16th are ignored. A sample presented in the same cycle as `line_start` is never counted.
- R4: In automatic mode (mode code 2'b00), a `line_start` loads the offset with target minus back-porch level, but only if 16 samples were gathered since the previous `line_start`. Otherwise the previous offset is kept.
- R5: An offset changes only on a `line_start` cycle. The sample presented in that same cycle is still corrected with the old offset.
- R6: In frozen mode (mode codes 2'b10 and 2'b11), a `line_start` leaves the offset unchanged, and the held offset keeps being applied.
- R7: In manual mode (mode code 2'b01), a `line_start` loads the offset from that channel's manual input. The manual input is a two's-complement value of DW+1 bits.
- R8: `mode_a` and `tgt_a` govern channel A only. `mode_bc` and `tgt_bc` govern channels B and C, and each of those keeps its own measurement and offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_a | input | 2 | Loop mode for channel A: 00 auto, 01 manual, 1x frozen |
| mode_bc | input | 2 | Loop mode shared by channels B and C |
| tgt_a | input | DW | Black-level target for channel A |
| tgt_bc | input | DW | Black-level target for channels B and C |
| man_a | input | DW+1 | Signed manual offset, channel A |
| man_b | input | DW+1 | Signed manual offset, channel B |
| man_c | input | DW+1 | Signed manual offset, channel C |
| line_start | input | 1 | Line-start strobe; offset update point |
| bp_win | input | 1 | Back-porch measurement window |
| in_vld | input | 1 | Input samples valid |
| in_a | input | DW | Channel A sample |
| in_b | input | DW | Channel B sample |
| in_c | input | DW | Channel C sample |
| out_vld | output | 1 | Corrected samples valid |
| out_a | output | DW | Corrected channel A sample |
| out_b | output | DW | Corrected channel B sample |
| out_c | output | DW | Corrected channel C sample |

## Verification
A wrong offset register shows up as a constant shift on every valid sample of that channel. It becomes visible on the output one clock after the line-start strobe that loaded it, and it persists until the next line-start. A wrong accumulator or sample count only shows after the following line-start, as an offset that disagrees with target minus the average of the first 16 window samples. A wrong clip shows only on samples whose sum leaves the code range. The bench therefore places samples at both code extremes.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
  typedef enum logic [1:0] {
    CLP_AUTO   = 2'b00,
    CLP_MANUAL = 2'b01,
    CLP_HOLD   = 2'b10,
    CLP_HOLD_X = 2'b11
  } clamp_mode_e;
endpackage

// File: rtl/clamp_meas.sv
module clamp_meas #(
  parameter int DW       = 10,
  parameter int AVG_LOG2 = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          smp_en,
  input  logic [DW-1:0] smp,
  output logic [DW-1:0] avg,
  output logic          full
);
  localparam int NS = 1 << AVG_LOG2;
  localparam int CW = AVG_LOG2 + 1;
  localparam int AW = DW + AVG_LOG2;

  logic [AW-1:0] acc_q, acc_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          acc_en;

  assign full = (cnt_q == CW'(NS));
  assign avg  = acc_q[AW-1:AVG_LOG2];

  always_comb begin
    acc_d  = acc_q;
    cnt_d  = cnt_q;
    acc_en = 1'b0;
    if (line_start) begin
      acc_d  = '0;
      cnt_d  = '0;
      acc_en = 1'b1;
    end else if (smp_en && !full) begin
      acc_d  = acc_q + AW'(smp);
      cnt_d  = cnt_q + 1'b1;
      acc_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  // R3: once full, a window sample leaves the accumulator untouched
  p_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !line_start) |=> $stable(acc_q));
endmodule

// File: rtl/clamp_loop.sv
module clamp_loop
  import clamp_pkg::*;
#(
  parameter int DW = 10,
  parameter int OW = DW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_start,
  input  clamp_mode_e          mode,
  input  logic [DW-1:0]        target,
  input  logic signed [OW-1:0] man_off,
  input  logic [DW-1:0]        avg,
  input  logic                 full,
  output logic signed [OW-1:0] off
);
  logic signed [OW-1:0] off_q, off_d;
  logic                 off_en;

  always_comb begin
    off_d  = off_q;
    off_en = 1'b0;
    if (line_start) begin
      case (mode)
        CLP_AUTO: begin
          if (full) begin
            off_d  = $signed({1'b0, target}) - $signed({1'b0, avg});
            off_en = 1'b1;
          end
        end
        CLP_MANUAL: begin
          off_d  = man_off;
          off_en = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= '0;
    else if (off_en) off_q <= off_d;
  end

  assign off = off_q;

  p_midline_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(off_q));
  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && mode[1]) |=> $stable(off_q));
  p_manual_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && mode == CLP_MANUAL) |=> (off_q == $past(man_off)));
  p_short_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && mode == CLP_AUTO && !full) |=> $stable(off_q));
endmodule

// File: rtl/clamp_corr.sv
module clamp_corr #(
  parameter int DW = 10,
  parameter int OW = DW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [DW-1:0]        smp,
  input  logic signed [OW-1:0] off,
  output logic [DW-1:0]        res
);
  localparam int SW = DW + 2;

  logic signed [SW-1:0] sum;
  logic [DW-1:0]        res_d, res_q;

  always_comb begin
    sum = $signed({2'b00, smp}) + $signed({{(SW-OW){off[OW-1]}}, off});
    if (sum < 0)
      res_d = '0;
    else if (sum > $signed({2'b00, {DW{1'b1}}}))
      res_d = {DW{1'b1}};
    else
      res_d = sum[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (in_vld) res_q <= res_d;
  end

  assign res = res_q;

  p_zero_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && off == '0) |=> (res == $past(smp)));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(res));
endmodule

// File: rtl/vid_clamp_top.sv
module vid_clamp_top
  import clamp_pkg::*;
#(
  parameter int DW       = 10,
  parameter int AVG_LOG2 = 4,
  parameter int NCH      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_a,
  input  logic [1:0]         mode_bc,
  input  logic [DW-1:0]      tgt_a,
  input  logic [DW-1:0]      tgt_bc,
  input  logic signed [DW:0] man_a,
  input  logic signed [DW:0] man_b,
  input  logic signed [DW:0] man_c,
  input  logic               line_start,
  input  logic               bp_win,
  input  logic               in_vld,
  input  logic [DW-1:0]      in_a,
  input  logic [DW-1:0]      in_b,
  input  logic [DW-1:0]      in_c,
  output logic               out_vld,
  output logic [DW-1:0]      out_a,
  output logic [DW-1:0]      out_b,
  output logic [DW-1:0]      out_c
);
  localparam int OW = DW + 1;

  logic [DW-1:0]        smp   [NCH];
  logic [DW-1:0]        res   [NCH];
  logic signed [OW-1:0] man   [NCH];
  logic signed [OW-1:0] off   [NCH];
  logic [DW-1:0]        avg   [NCH];
  logic                 full  [NCH];
  logic                 smp_en;
  logic                 vld_q;

  assign smp[0] = in_a;
  assign smp[1] = in_b;
  assign smp[2] = in_c;
  assign man[0] = man_a;
  assign man[1] = man_b;
  assign man[2] = man_c;
  assign smp_en = bp_win && in_vld;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    clamp_mode_e   ch_mode;
    logic [DW-1:0] ch_tgt;
    if (ch == 0) begin : g_sel_a
      assign ch_mode = clamp_mode_e'(mode_a);
      assign ch_tgt  = tgt_a;
    end else begin : g_sel_bc
      assign ch_mode = clamp_mode_e'(mode_bc);
      assign ch_tgt  = tgt_bc;
    end

    clamp_meas #(.DW(DW), .AVG_LOG2(AVG_LOG2)) i_meas (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .smp_en(smp_en),
      .smp(smp[ch]), .avg(avg[ch]), .full(full[ch]));

    clamp_loop #(.DW(DW), .OW(OW)) i_loop (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .mode(ch_mode),
      .target(ch_tgt), .man_off(man[ch]), .avg(avg[ch]), .full(full[ch]),
      .off(off[ch]));

    clamp_corr #(.DW(DW), .OW(OW)) i_corr (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .smp(smp[ch]),
      .off(off[ch]), .res(res[ch]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_vld;
  end

  assign out_vld = vld_q;
  assign out_a   = res[0];
  assign out_b   = res[1];
  assign out_c   = res[2];

  p_vld_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == $past(in_vld));
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |-> !out_vld);
endmodule

// File: tb/test_vid_clamp_top.sv
module test_vid_clamp_top;
  localparam int DW   = 10;
  localparam int MAXV = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode_a, mode_bc;
  logic [DW-1:0] tgt_a, tgt_bc;
  logic signed [DW:0] man_a, man_b, man_c;
  logic line_start, bp_win, in_vld;
  logic [DW-1:0] in_a, in_b, in_c;
  logic out_vld;
  logic [DW-1:0] out_a, out_b, out_c;

  always #2 clk = ~clk;

  vid_clamp_top i_vid_clamp_top (
    .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_bc(mode_bc),
    .tgt_a(tgt_a), .tgt_bc(tgt_bc), .man_a(man_a), .man_b(man_b), .man_c(man_c),
    .line_start(line_start), .bp_win(bp_win), .in_vld(in_vld),
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_vld(out_vld), .out_a(out_a), .out_b(out_b), .out_c(out_c));

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;
  int qa[$], qb[$], qc[$];
  string qt[$];
  int m_off[3], m_acc[3], m_cnt[3];

  function automatic int sat(int v);
    if (v < 0) return 0;
    if (v > MAXV) return MAXV;
    return v;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops the oldest expected item whenever the design presents a result
  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      if (qa.size() == 0) begin
        chk("R2", "output without pending input", 1, 0);
      end else begin
        string t;
        int ea, eb, ec;
        ea = qa.pop_front(); eb = qb.pop_front(); ec = qc.pop_front();
        t  = qt.pop_front();
        chk(t, "chan A", int'(out_a), ea);
        chk(t, "chan B", int'(out_b), eb);
        chk(t, "chan C", int'(out_c), ec);
      end
    end
  end

  // driver: one cycle of stimulus plus the expected-value model from the requirements
  task automatic cyc(bit ls, bit bp, bit vld, int sa, int sb, int sc, string tag);
    int s[3];
    int mv[3];
    int md, tg;
    @(negedge clk);
    line_start = ls; bp_win = bp; in_vld = vld;
    in_a = DW'(sa); in_b = DW'(sb); in_c = DW'(sc);
    s[0] = sa; s[1] = sb; s[2] = sc;
    mv[0] = int'(man_a); mv[1] = int'(man_b); mv[2] = int'(man_c);
    if (vld) begin  // R5: same-cycle sample uses the old offset
      qa.push_back(sat(sa + m_off[0]));
      qb.push_back(sat(sb + m_off[1]));
      qc.push_back(sat(sc + m_off[2]));
      qt.push_back(tag);
    end
    for (int ch = 0; ch < 3; ch++) begin
      md = (ch == 0) ? int'(mode_a) : int'(mode_bc);
      tg = (ch == 0) ? int'(tgt_a) : int'(tgt_bc);
      if (ls) begin
        if (md == 0 && m_cnt[ch] == 16) m_off[ch] = tg - (m_acc[ch] >> 4);
        else if (md == 1)               m_off[ch] = mv[ch];
        m_acc[ch] = 0;
        m_cnt[ch] = 0;
      end else if (bp && vld && m_cnt[ch] < 16) begin
        m_acc[ch] += s[ch];
        m_cnt[ch]++;
      end
    end
  endtask

  // one line: strobe cycle (with window high and an outlier sample), idle,
  // back-porch samples (value changes to far after sample 'knee'), active samples
  task automatic run_line(int nbp, int knee, int ba, int bb, int bc, int alt, string tag);
    cyc(1, 1, 1, 1000, 1000, 1000, tag);
    cyc(0, 0, 0, 0, 0, 0, tag);
    for (int i = 0; i < nbp; i++) begin
      if (i < knee) cyc(0, 1, 1, ba + (i % 2) * alt, bb, bc, tag);
      else          cyc(0, 1, 1, 900, 900, 900, tag);
    end
    cyc(0, 0, 1, 0, 0, 0, tag);
    cyc(0, 0, 1, 100, 100, 100, tag);
    cyc(0, 0, 0, 7, 7, 7, tag);
    cyc(0, 0, 1, 512, 512, 512, tag);
    cyc(0, 0, 1, 1000, 1000, 1000, tag);
    cyc(0, 0, 1, MAXV, MAXV, MAXV, tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int ch = 0; ch < 3; ch++) begin
      m_off[ch] = 0; m_acc[ch] = 0; m_cnt[ch] = 0;
    end
    rst_n = 1'b0;
    mode_a = 2'b00; mode_bc = 2'b00; tgt_a = 10'd64; tgt_bc = 10'd512;
    man_a = '0; man_b = '0; man_c = '0;
    line_start = 0; bp_win = 0; in_vld = 0; in_a = 0; in_b = 0; in_c = 0;
    repeat (3) @(negedge clk);
    chk("R1", "out_vld in reset", int'(out_vld), 0);
    chk("R1", "out_a in reset", int'(out_a), 0);
    @(negedge clk); rst_n = 1'b1;
    // R1: first line passes through with zero offsets
    run_line(16, 16, 60, 500, 520, 0, "R1");
    // R4: offsets +4/+12/-8 from line 1; new mixed-level measurement
    run_line(16, 16, 100, 400, 600, 1, "R4");
    // R4: short window (8 samples) keeps -36/+112/-88
    run_line(8, 8, 10, 10, 10, 0, "R4");
    // R3: only the first 16 window samples count
    run_line(20, 16, 70, 530, 490, 0, "R3");
    // R6/R8: A frozen, B and C keep tracking
    mode_a = 2'b10;
    run_line(16, 16, 20, 300, 700, 0, "R6");
    run_line(16, 16, 30, 450, 450, 0, "R8");
    // R7: manual offsets, with clipping at both ends
    mode_a = 2'b01; mode_bc = 2'b01;
    man_a = -11'sd5; man_b = 11'sd300; man_c = -11'sd500;
    run_line(16, 16, 40, 40, 40, 0, "R7");
    run_line(4, 4, 40, 40, 40, 0, "R2");
    // R6/R8: B and C frozen with code 11, A back to automatic
    mode_a = 2'b00; mode_bc = 2'b11;
    man_b = 11'sd0; man_c = 11'sd0;
    run_line(16, 16, 50, 200, 800, 0, "R6");
    run_line(16, 16, 64, 512, 512, 0, "R8");
    repeat (4) cyc(0, 0, 0, 0, 0, 0, "R2");
    chk("R2", "pending results after drain", qa.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule